// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable integer N and emits one pulse per N input cycles, which a phase/frequency detector then compares against a reference. The divider does not use a single wide modulo counter. It is built as a digital model of a dual-modulus prescaler that divides by P or P+1. Two down counters steer that prescaler: a 5-bit swallow counter (A) and a 13-bit main counter (B). The total ratio is N = P·B + A.

In each output period, the prescaler divides by P+1 for the first A prescaler cycles. It divides by P for the remaining B−A cycles. A select bit picks the modulus pair. The `LOW_BAND` build parameter lowers both moduli to give the low-frequency variant. New A, B and select values are taken only at a period boundary. A hold input (power-down) and a divider-reset input both park the counters at their load point. Counting restarts from that load point once the input is released.

A configuration with B below 3, or with A above B, raises an illegal-configuration flag. The divider keeps running with clamped values in that case.

Top module: `fdiv_pulse_swallow`

## Requirements
- R1: Between two consecutive output pulses there are exactly N = P·B + A input clock cycles, where A and B are the values in force for that period.
- R2: With `LOW_BAND` = 0, `pre_sel` = 0 gives P = 16 (modulus pair 16/17) and `pre_sel` = 1 gives P = 32 (pair 32/33).
- R3: With `LOW_BAND` = 1, `pre_sel` = 0 gives P = 8 (pair 8/9) and `pre_sel` = 1 gives P = 16 (pair 16/17).
- R4: `div_pulse` is high for exactly one input clock cycle per period.
- R5: `a_val`, `b_val` and `pre_sel` are sampled only at a period boundary. A change in the middle of a period leaves that period's length unchanged, and the next period uses the new values.
- R6: While `hold` is high, no pulse is produced and the counters sit at their load point. After `hold` falls, the first pulse follows N+1 clock edges later: one edge to load, then N counted cycles.
- R7: A one-cycle `div_rst` abandons the current period. The first pulse then follows N+1 edges after `div_rst` falls.
- R8: When the sampled B is below 3 or the sampled A exceeds B, `cfg_err` is high for that period. B is then clamped up to 3 and A is clamped down to B. A legal configuration returns `cfg_err` to 0 at its next load.
- R9: While `rst_n` is low, `div_pulse` and `cfg_err` are 0. After release, the first edge loads the configuration, and the first pulse arrives N+1 edges after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_sel | input | 1 | Modulus pair select (0 = lower pair, 1 = upper pair) |
| a_val | input | A_W (5) | Swallow count A |
| b_val | input | B_W (13) | Main count B |
| hold | input | 1 | Power-down: freeze at the load point |
| div_rst | input | 1 | Synchronous return to the load point |
| div_pulse | output | 1 | One-cycle divided output pulse |
| cfg_err | output | 1 | Configuration of the current period was illegal |

## Verification
The checker assumes the inputs change only away from the active clock edge. It also assumes that every loaded period spans more than one input cycle, which holds for any clamped configuration, since N is at least 3·P. The pulse-width and idle properties depend on that. The swallow-ordering properties rely on the clamp keeping A at or below B, so out-of-range stimulus is safe to apply. The bench drives every input on the falling edge, and it runs illegal settings only on purpose, to exercise the clamp and the flag.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
   // Lower modulus of the pair chosen by the select bit.
   function automatic int unsigned fdiv_low_mod(input bit low_band, input bit sel);
      if (low_band) return sel ? 16 : 8;
      return sel ? 32 : 16;
   endfunction
   localparam int unsigned FDIV_MAX_MOD = 33;
endpackage

// File: rtl/fdiv_cfg.sv
module fdiv_cfg #(
   parameter int A_W   = 5,
   parameter int B_W   = 13,
   parameter int B_MIN = 3
) (
   input  logic [A_W-1:0] a_in,
   input  logic [B_W-1:0] b_in,
   output logic [A_W-1:0] a_eff,
   output logic [B_W-1:0] b_eff,
   output logic           bad
);
   localparam int PAD = B_W - A_W;
   logic [B_W-1:0] a_wide;
   logic           b_low;

   always_comb begin
      a_wide = {{PAD{1'b0}}, a_in};
      b_low  = (b_in < B_W'(B_MIN));
      b_eff  = b_low ? B_W'(B_MIN) : b_in;
      bad    = b_low | (a_wide > b_in);
      a_eff  = (a_wide > b_eff) ? b_eff[A_W-1:0] : a_in;
   end
endmodule

// File: rtl/fdiv_prescaler.sv
module fdiv_prescaler #(
   parameter int PC_W     = 6,
   parameter bit LOW_BAND = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            freeze,
   input  logic            restart,
   input  logic            sel_act,
   input  logic            swallow,
   output logic [PC_W-1:0] pc,
   output logic [PC_W-1:0] low_mod,
   output logic            cyc_end
);
   import fdiv_pkg::*;
   logic [PC_W-1:0] modulus;
   logic [PC_W-1:0] pc_q;

   generate
      if (LOW_BAND) begin : g_low
         assign low_mod = sel_act ? PC_W'(fdiv_low_mod(1'b1, 1'b1))
                                  : PC_W'(fdiv_low_mod(1'b1, 1'b0));
      end else begin : g_high
         assign low_mod = sel_act ? PC_W'(fdiv_low_mod(1'b0, 1'b1))
                                  : PC_W'(fdiv_low_mod(1'b0, 1'b0));
      end
   endgenerate

   assign modulus = swallow ? low_mod + PC_W'(1) : low_mod;
   assign cyc_end = !freeze && !restart && (pc_q == modulus - PC_W'(1));
   assign pc      = pc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pc_q <= '0;
      else if (freeze || restart)  pc_q <= '0;
      else if (cyc_end)            pc_q <= '0;
      else                         pc_q <= pc_q + PC_W'(1);
   end
endmodule

// File: rtl/fdiv_counters.sv
module fdiv_counters #(
   parameter int A_W = 5,
   parameter int B_W = 13
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           freeze,
   input  logic           cyc_end,
   input  logic [A_W-1:0] a_eff,
   input  logic [B_W-1:0] b_eff,
   input  logic           bad,
   input  logic           sel_in,
   output logic           at_load,
   output logic [A_W-1:0] ac,
   output logic [B_W-1:0] bc,
   output logic           sel_act,
   output logic           err,
   output logic           pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         at_load <= 1'b1;
         ac      <= '0;
         bc      <= '0;
         sel_act <= 1'b0;
         err     <= 1'b0;
         pulse   <= 1'b0;
      end else if (freeze) begin
         at_load <= 1'b1;
         pulse   <= 1'b0;
      end else if (at_load || (cyc_end && bc == B_W'(1))) begin
         at_load <= 1'b0;
         ac      <= a_eff;
         bc      <= b_eff;
         sel_act <= sel_in;
         err     <= bad;
         pulse   <= !at_load;
      end else if (cyc_end) begin
         bc      <= bc - B_W'(1);
         if (ac != '0) ac <= ac - A_W'(1);
         pulse   <= 1'b0;
      end else begin
         pulse   <= 1'b0;
      end
   end
endmodule

// File: rtl/fdiv_pulse_swallow.sv
module fdiv_pulse_swallow #(
   parameter int A_W      = 5,
   parameter int B_W      = 13,
   parameter int B_MIN    = 3,
   parameter bit LOW_BAND = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pre_sel,
   input  logic [A_W-1:0] a_val,
   input  logic [B_W-1:0] b_val,
   input  logic           hold,
   input  logic           div_rst,
   output logic           div_pulse,
   output logic           cfg_err
);
   localparam int PC_W = $clog2(fdiv_pkg::FDIV_MAX_MOD + 1);

   generate
      if (A_W > B_W) begin : g_bad_width
         $error("swallow counter wider than main counter");
      end
      if (B_MIN < 2) begin : g_bad_min
         $error("minimum main count must be at least 2");
      end
   endgenerate

   logic           freeze;
   logic [A_W-1:0] a_eff;
   logic [B_W-1:0] b_eff;
   logic           bad;
   logic           at_load;
   logic [A_W-1:0] ac;
   logic [B_W-1:0] bc;
   logic           sel_act;
   logic [PC_W-1:0] pc;
   logic [PC_W-1:0] low_mod;
   logic           cyc_end;

   assign freeze = hold | div_rst;

   fdiv_cfg #(.A_W(A_W), .B_W(B_W), .B_MIN(B_MIN)) u_cfg (
      .a_in(a_val), .b_in(b_val), .a_eff(a_eff), .b_eff(b_eff), .bad(bad)
   );

   fdiv_prescaler #(.PC_W(PC_W), .LOW_BAND(LOW_BAND)) u_pre (
      .clk(clk), .rst_n(rst_n), .freeze(freeze), .restart(at_load),
      .sel_act(sel_act), .swallow(ac != '0),
      .pc(pc), .low_mod(low_mod), .cyc_end(cyc_end)
   );

   fdiv_counters #(.A_W(A_W), .B_W(B_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .freeze(freeze), .cyc_end(cyc_end),
      .a_eff(a_eff), .b_eff(b_eff), .bad(bad), .sel_in(pre_sel),
      .at_load(at_load), .ac(ac), .bc(bc), .sel_act(sel_act),
      .err(cfg_err), .pulse(div_pulse)
   );
endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker #(
   parameter int A_W  = 5,
   parameter int B_W  = 13,
   parameter int PC_W = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            hold,
   input logic            div_rst,
   input logic            div_pulse,
   input logic            at_load,
   input logic [A_W-1:0]  ac,
   input logic [B_W-1:0]  bc,
   input logic [PC_W-1:0] pc,
   input logic [PC_W-1:0] low_mod
);
   localparam int PAD = B_W - A_W;

   AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse); // R4

   AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !div_pulse); // R6

   AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      div_rst |=> !div_pulse && at_load); // R7

   AST_SWALLOW_LE_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
      !at_load |-> ({{PAD{1'b0}}, ac} <= bc)); // R8

   AST_LOW_MODULUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!at_load && ac == '0) |-> (pc < low_mod)); // R1
endmodule

bind fdiv_pulse_swallow fdiv_checker #(.A_W(A_W), .B_W(B_W), .PC_W(PC_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .hold(hold), .div_rst(div_rst),
   .div_pulse(div_pulse), .at_load(at_load), .ac(ac), .bc(bc),
   .pc(pc), .low_mod(low_mod)
);

// File: tb/test_fdiv_pulse_swallow.sv
module test_fdiv_pulse_swallow;
   localparam int CLK_PERIOD = 10;
   localparam int LIMIT      = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pre_sel = 1'b0;
   logic [4:0]  a_val = '0;
   logic [12:0] b_val = 13'd20;
   logic        hold = 1'b0;
   logic        div_rst = 1'b0;
   logic        div_pulse, cfg_err, pulse_lb, err_lb;
   int          n_chk = 0;
   int          n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fdiv_pulse_swallow i_fdiv_pulse_swallow (
      .clk(clk), .rst_n(rst_n), .pre_sel(pre_sel), .a_val(a_val), .b_val(b_val),
      .hold(hold), .div_rst(div_rst), .div_pulse(div_pulse), .cfg_err(cfg_err)
   );

   fdiv_pulse_swallow #(.LOW_BAND(1'b1)) i_lowband (
      .clk(clk), .rst_n(rst_n), .pre_sel(pre_sel), .a_val(a_val), .b_val(b_val),
      .hold(hold), .div_rst(div_rst), .div_pulse(pulse_lb), .cfg_err(err_lb)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // Counts falling edges until the selected pulse is seen high.
   task automatic wait_pulse(input bit lb, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!(lb ? pulse_lb : div_pulse) && n < LIMIT);
   endtask

   task automatic drive(input bit s, input int a, input int b);
      pre_sel = s;
      a_val   = 5'(a);
      b_val   = 13'(b);
   endtask

   task automatic run_cfg(input bit lb, input bit s, input int a, input int b,
                          input int exp_n, input bit exp_err, input string req);
      int n;
      drive(s, a, b);
      wait_pulse(lb, n);
      wait_pulse(lb, n);
      chk(n == exp_n, req, n, exp_n);
      chk((lb ? err_lb : cfg_err) == exp_err, "R8", int'(lb ? err_lb : cfg_err), int'(exp_err));
      @(negedge clk);
      chk(!(lb ? pulse_lb : div_pulse), "R4", int'(lb ? pulse_lb : div_pulse), 0);
   endtask

   task automatic t_reset();
      int n;
      drive(1'b0, 5, 20);
      repeat (4) begin
         @(negedge clk);
         chk(!div_pulse && !cfg_err, "R9 reset", int'({div_pulse, cfg_err}), 0);
      end
      rst_n = 1'b1;
      wait_pulse(1'b0, n);
      chk(n == 326, "R9 first pulse", n, 326);
   endtask

   task automatic t_ratio();
      run_cfg(1'b0, 1'b0, 5, 20, 325, 1'b0, "R1 P16 B20 A5");
      run_cfg(1'b0, 1'b1, 31, 31, 1023, 1'b0, "R2 P32 B31 A31");
      run_cfg(1'b0, 1'b0, 0, 3, 48, 1'b0, "R1 P16 B3 A0");
      run_cfg(1'b0, 1'b1, 0, 3, 96, 1'b0, "R2 P32 B3 A0");
   endtask

   task automatic t_boundary();
      int n;
      drive(1'b0, 7, 10);
      wait_pulse(1'b0, n);
      wait_pulse(1'b0, n);
      repeat (10) @(negedge clk);
      drive(1'b1, 2, 4);
      wait_pulse(1'b0, n);
      chk(n + 10 == 167, "R5 old period kept", n + 10, 167);
      wait_pulse(1'b0, n);
      chk(n == 130, "R5 new period", n, 130);
   endtask

   task automatic t_hold();
      int n;
      int seen;
      drive(1'b0, 5, 20);
      wait_pulse(1'b0, n);
      repeat (7) @(negedge clk);
      hold = 1'b1;
      seen = 0;
      for (int i = 0; i < 700; i++) begin
         @(negedge clk);
         if (div_pulse) seen++;
      end
      chk(seen == 0, "R6 quiet in hold", seen, 0);
      hold = 1'b0;
      wait_pulse(1'b0, n);
      chk(n == 326, "R6 resume from load", n, 326);
   endtask

   task automatic t_divrst();
      int n;
      wait_pulse(1'b0, n);
      repeat (100) @(negedge clk);
      div_rst = 1'b1;
      @(negedge clk);
      chk(!div_pulse, "R7 no pulse", int'(div_pulse), 0);
      div_rst = 1'b0;
      wait_pulse(1'b0, n);
      chk(n == 326, "R7 restart", n, 326);
   endtask

   task automatic t_illegal();
      run_cfg(1'b0, 1'b0, 1, 2, 49, 1'b1, "R8 B below min");
      run_cfg(1'b0, 1'b0, 9, 4, 68, 1'b1, "R8 A above B");
      run_cfg(1'b0, 1'b0, 3, 3, 51, 1'b0, "R8 legal again");
   endtask

   task automatic t_lowband();
      run_cfg(1'b1, 1'b0, 3, 7, 59, 1'b0, "R3 P8 B7 A3");
      run_cfg(1'b1, 1'b1, 2, 5, 82, 1'b0, "R3 P16 B5 A2");
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      t_reset();
      t_ratio();
      t_boundary();
      t_hold();
      t_divrst();
      t_illegal();
      t_lowband();
      finish_run();
   end
endmodule